// File: doc/BRIEF.md
# Clock Source Select Controller

This block decides which clock source feeds the system clocks of a microcontroller clock generator, and which of the derived clock domains may run. The decisions are made as synchronous enable signals, so no clock is gated here. The block weighs a software-written control word, a wait-mode request and release, the PLL lock status and the self-clock-mode status. From these it produces the selected source, run enables for the system and core clocks, a PLL power enable, a bus tick enable and the effective auto-bandwidth setting.

Software writes the whole control word through a single write strobe and can read it back. Entering wait mode with the PLL-stop-in-wait policy set clears the PLL-select field in hardware, which forces a later rewrite before the PLL drives the system again. Self-clock mode overrides the source choice so that the PLL is used regardless of the select field.

Top module: `clksel_top`

## Requirements
- R1: After reset the control word reads 0, the source is the oscillator (`src_pll`=0), `sys_run_en`=1, `core_run_en`=1, `pll_pwr_en`=0, `auto_bw_eff`=0 and `lock_warn`=0.
- R2: A cycle with `wr_en`=1 loads `wr_data` into the control word, visible on `ctrl_q` after that clock edge. Field positions are: bit 0 PLL select, bit 1 system-stop-in-wait, bit 2 core-stop-in-wait, bit 3 PLL-stop-in-wait, bit 4 auto-bandwidth, bit 5 PLL on.
- R3: `src_pll` is 1 when the PLL select bit is 1 or `self_clk_mode` is 1, and 0 otherwise. While `self_clk_mode` is 1, `pll_pwr_en` is 1 even if PLL on is 0.
- R4: While the system clock runs, `bus_en` is high on every second cycle and never on two consecutive cycles. On the cycle the selected source changes, the divider restarts: `bus_en` is 0 on that cycle and 1 on the next.
- R5: A `wait_req` pulse outside wait enters wait mode. If PLL-stop-in-wait is 1, the PLL select bit is cleared on entry, PLL on keeps its value, and `pll_pwr_en` is 0 for the whole wait. If PLL-stop-in-wait is 0, PLL select is kept.
- R6: After a `wait_rel` pulse ends wait mode, the PLL select bit stays 0 until software writes it to 1 again.
- R7: `auto_bw_eff` is 1 whenever the auto-bandwidth bit or the PLL-stop-in-wait bit is 1. The stored auto-bandwidth bit itself is not changed.
- R8: During wait with system-stop-in-wait set, `sys_run_en`, `core_run_en` and `bus_en` are all 0. They return once wait ends.
- R9: During wait with only core-stop-in-wait set, `core_run_en` is 0 while `sys_run_en` stays 1 and `bus_en` keeps pulsing.
- R10: A write that sets PLL select while `pll_lock`=0 is accepted and sets `lock_warn`. `lock_warn` then stays 1 until reset. A write with `pll_lock`=1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one system tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control word to write |
| wait_req | input | 1 | Single-cycle wait-mode entry pulse |
| wait_rel | input | 1 | Single-cycle wait-mode exit pulse |
| pll_lock | input | 1 | PLL lock status |
| self_clk_mode | input | 1 | Self-clock-mode status |
| ctrl_q | output | 6 | Stored control word |
| src_pll | output | 1 | Selected source, 1 = PLL, 0 = oscillator |
| sys_run_en | output | 1 | System clock run enable |
| core_run_en | output | 1 | Core clock run enable |
| pll_pwr_en | output | 1 | PLL power enable |
| bus_en | output | 1 | Bus tick enable, every second system tick |
| auto_bw_eff | output | 1 | Effective auto-bandwidth bit |
| lock_warn | output | 1 | Sticky warning: PLL selected while unlocked |

## Verification
The hardest state to reach is the hardware clearing of the PLL select bit. It needs PLL select and PLL-stop-in-wait written together, a wait entry, and then a release with no intervening write. Only then can the bench show that the bit stays cleared after wait and that the PLL was unpowered throughout. The bench writes that combination, pulses the entry, and holds wait for several cycles while sampling the power enable. It then releases and idles before rewriting the select bit. The divider restart is reached by writing a new select value and sampling `bus_en` on the first two cycles after the write edge, independent of the phase held before.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int CTRL_W  = 6;
    localparam int F_SEL   = 0;
    localparam int F_SYSW  = 1;
    localparam int F_COREW = 2;
    localparam int F_PLLW  = 3;
    localparam int F_AUTO  = 4;
    localparam int F_PLLON = 5;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } src_e;

    // packed MSB first: pll_sel lands on bit 0
    typedef struct packed {
        logic pll_on;
        logic auto_bw;
        logic pll_stop_w;
        logic core_stop_w;
        logic sys_stop_w;
        logic pll_sel;
    } ctrl_t;

    typedef struct packed {
        logic sys_run;
        logic core_run;
        logic pll_pwr;
    } run_t;

    // hardware side effect of entering wait mode
    function automatic ctrl_t wait_entry_fix(ctrl_t c);
        ctrl_t r;
        r = c;
        if (c.pll_stop_w) r.pll_sel = 1'b0;
        return r;
    endfunction

    function automatic src_e pick_source(ctrl_t c, logic scm);
        return (scm || c.pll_sel) ? SRC_PLL : SRC_OSC;
    endfunction

endpackage

// File: rtl/clksel_ctrl_reg.sv
module clksel_ctrl_reg
    import clksel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_word,
    input  logic  wait_req,
    input  logic  wait_rel,
    input  logic  pll_lock,
    output ctrl_t ctrl_q,
    output logic  in_wait,
    output logic  lock_warn
);

    ctrl_t ctrl_nxt;
    logic  enter;

    always_comb begin
        enter    = wait_req && !in_wait;
        ctrl_nxt = ctrl_q;
        if (wr_en) ctrl_nxt = wr_word;
        if (enter) ctrl_nxt = wait_entry_fix(ctrl_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            in_wait   <= 1'b0;
            lock_warn <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (enter)
                in_wait <= 1'b1;
            else if (wait_rel)
                in_wait <= 1'b0;
            if (wr_en && wr_word.pll_sel && !pll_lock)
                lock_warn <= 1'b1;
        end
    end

endmodule

// File: rtl/clksel_gate.sv
module clksel_gate
    import clksel_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  in_wait,
    input  logic  scm,
    output src_e  src,
    output run_t  run,
    output logic  auto_bw_eff
);

    always_comb begin
        src          = pick_source(ctrl, scm);
        run.sys_run  = !(in_wait && ctrl.sys_stop_w);
        run.core_run = run.sys_run && !(in_wait && ctrl.core_stop_w);
        run.pll_pwr  = scm || (ctrl.pll_on && !(in_wait && ctrl.pll_stop_w));
        auto_bw_eff  = ctrl.auto_bw || ctrl.pll_stop_w;
    end

endmodule

// File: rtl/clksel_busdiv.sv
module clksel_busdiv
    import clksel_pkg::*;
#(
    parameter int BUS_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic sys_run,
    output logic bus_en
);

    localparam int CW = (BUS_DIV < 2) ? 1 : $clog2(BUS_DIV);
    localparam logic [CW-1:0] LAST = CW'(BUS_DIV - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_eff;
    logic [CW-1:0] cnt_nxt;
    src_e          src_q;

    always_comb begin
        cnt_eff = (src == src_q) ? cnt : '0;
        bus_en  = sys_run && (cnt_eff == LAST);
        if (!sys_run)
            cnt_nxt = cnt_eff;
        else if (cnt_eff == LAST)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_eff + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            src_q <= SRC_OSC;
        end else begin
            cnt   <= cnt_nxt;
            src_q <= src;
        end
    end

endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int BUS_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wait_req,
    input  logic              wait_rel,
    input  logic              pll_lock,
    input  logic              self_clk_mode,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              src_pll,
    output logic              sys_run_en,
    output logic              core_run_en,
    output logic              pll_pwr_en,
    output logic              bus_en,
    output logic              auto_bw_eff,
    output logic              lock_warn
);

    ctrl_t ctrl;
    logic  in_wait;
    src_e  src;
    run_t  run;

    clksel_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (ctrl_t'(wr_data)),
        .wait_req  (wait_req),
        .wait_rel  (wait_rel),
        .pll_lock  (pll_lock),
        .ctrl_q    (ctrl),
        .in_wait   (in_wait),
        .lock_warn (lock_warn)
    );

    clksel_gate u_gate (
        .ctrl        (ctrl),
        .in_wait     (in_wait),
        .scm         (self_clk_mode),
        .src         (src),
        .run         (run),
        .auto_bw_eff (auto_bw_eff)
    );

    clksel_busdiv #(.BUS_DIV(BUS_DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .sys_run (run.sys_run),
        .bus_en  (bus_en)
    );

    assign ctrl_q      = ctrl;
    assign src_pll     = (src == SRC_PLL);
    assign sys_run_en  = run.sys_run;
    assign core_run_en = run.core_run;
    assign pll_pwr_en  = run.pll_pwr;

endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
    import clksel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wait_req,
    input logic              self_clk_mode,
    input logic              in_wait,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              src_pll,
    input logic              sys_run_en,
    input logic              core_run_en,
    input logic              bus_en,
    input logic              auto_bw_eff,
    input logic              lock_warn
);

    // R3
    scm_source_chk: assert property (@(posedge clk) disable iff (rst)
        self_clk_mode |-> src_pll);

    // R4
    bus_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> !bus_en);

    // R5
    wait_sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_req && !in_wait && ctrl_q[F_PLLW] && !wr_en) |=> (in_wait && !ctrl_q[F_SEL]));

    // R7
    auto_force_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[F_PLLW] |-> auto_bw_eff);

    // R8
    sys_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_run_en |-> (!core_run_en && !bus_en));

    // R10
    warn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_warn |=> lock_warn);

endmodule

bind clksel_top clksel_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wait_req      (wait_req),
    .self_clk_mode (self_clk_mode),
    .in_wait       (in_wait),
    .ctrl_q        (ctrl_q),
    .src_pll       (src_pll),
    .sys_run_en    (sys_run_en),
    .core_run_en   (core_run_en),
    .bus_en        (bus_en),
    .auto_bw_eff   (auto_bw_eff),
    .lock_warn     (lock_warn)
);

// File: tb/test_clksel_top.sv
`timescale 1ns/1ps
module test_clksel_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       wait_req = 1'b0;
    logic       wait_rel = 1'b0;
    logic       pll_lock = 1'b1;
    logic       self_clk_mode = 1'b0;
    logic [5:0] ctrl_q;
    logic       src_pll, sys_run_en, core_run_en, pll_pwr_en;
    logic       bus_en, auto_bw_eff, lock_warn;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clksel_top i_clksel_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wait_req(wait_req), .wait_rel(wait_rel), .pll_lock(pll_lock),
        .self_clk_mode(self_clk_mode), .ctrl_q(ctrl_q), .src_pll(src_pll),
        .sys_run_en(sys_run_en), .core_run_en(core_run_en),
        .pll_pwr_en(pll_pwr_en), .bus_en(bus_en),
        .auto_bw_eff(auto_bw_eff), .lock_warn(lock_warn)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [5:0] v);
        wr_en = 1'b1; wr_data = v;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic enter_wait();
        wait_req = 1'b1; cyc(); wait_req = 1'b0;
    endtask

    task automatic leave_wait();
        wait_rel = 1'b1; cyc(); wait_rel = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ctrl", 8'(ctrl_q), 8'h00);
        chk("R1 src", 8'(src_pll), 8'h0);
        chk("R1 sys", 8'(sys_run_en), 8'h1);
        chk("R1 core", 8'(core_run_en), 8'h1);
        chk("R1 pwr", 8'(pll_pwr_en), 8'h0);
        chk("R1 auto", 8'(auto_bw_eff), 8'h0);
        chk("R1 warn", 8'(lock_warn), 8'h0);
    endtask

    task automatic t_write();
        write_ctrl(6'h26);
        chk("R2 readback", 8'(ctrl_q), 8'h26);
        chk("R2 auto off", 8'(auto_bw_eff), 8'h0);
        write_ctrl(6'h00);
        chk("R2 cleared", 8'(ctrl_q), 8'h00);
    endtask

    task automatic t_source();
        int ones;
        logic prev;
        // R4 steady alternation
        ones = 0;
        cyc(); prev = bus_en;
        for (int i = 0; i < 8; i++) begin
            cyc();
            chk("R4 alternate", 8'(bus_en), 8'(!prev));
            prev = bus_en;
            if (bus_en) ones++;
        end
        chk("R4 ones", 8'(ones), 8'd4);
        // R3 select PLL, R4 restart on change
        write_ctrl(6'h21);
        chk("R3 src pll", 8'(src_pll), 8'h1);
        chk("R4 restart low", 8'(bus_en), 8'h0);
        cyc(); chk("R4 restart high", 8'(bus_en), 8'h1);
        cyc(); chk("R4 restart low2", 8'(bus_en), 8'h0);
        write_ctrl(6'h20);
        chk("R3 src osc", 8'(src_pll), 8'h0);
        chk("R4 back low", 8'(bus_en), 8'h0);
        cyc(); chk("R4 back high", 8'(bus_en), 8'h1);
        // R3 self clock override
        write_ctrl(6'h00);
        self_clk_mode = 1'b1;
        cyc();
        chk("R3 scm src", 8'(src_pll), 8'h1);
        chk("R3 scm pwr", 8'(pll_pwr_en), 8'h1);
        self_clk_mode = 1'b0;
        cyc();
        chk("R3 scm off src", 8'(src_pll), 8'h0);
        chk("R3 scm off pwr", 8'(pll_pwr_en), 8'h0);
    endtask

    task automatic t_wait_pll();
        write_ctrl(6'h29);
        chk("R7 forced auto", 8'(auto_bw_eff), 8'h1);
        chk("R7 stored auto", 8'(ctrl_q[4]), 8'h0);
        chk("R5 pwr before", 8'(pll_pwr_en), 8'h1);
        enter_wait();
        chk("R5 sel cleared", 8'(ctrl_q[0]), 8'h0);
        chk("R5 pll_on kept", 8'(ctrl_q[5]), 8'h1);
        chk("R5 src osc", 8'(src_pll), 8'h0);
        for (int i = 0; i < 3; i++) begin
            chk("R5 pwr off", 8'(pll_pwr_en), 8'h0);
            cyc();
        end
        leave_wait();
        chk("R6 pwr back", 8'(pll_pwr_en), 8'h1);
        repeat (3) cyc();
        chk("R6 sel stays 0", 8'(ctrl_q[0]), 8'h0);
        chk("R6 src osc", 8'(src_pll), 8'h0);
        write_ctrl(6'h29);
        chk("R6 rewrite", 8'(ctrl_q[0]), 8'h1);
        // PLL select kept without stop policy
        write_ctrl(6'h21);
        enter_wait();
        chk("R5 sel kept", 8'(ctrl_q[0]), 8'h1);
        chk("R5 pwr kept", 8'(pll_pwr_en), 8'h1);
        leave_wait();
        write_ctrl(6'h00);
        chk("R7 auto 0", 8'(auto_bw_eff), 8'h0);
        write_ctrl(6'h10);
        chk("R7 auto bit", 8'(auto_bw_eff), 8'h1);
    endtask

    task automatic t_wait_sys();
        write_ctrl(6'h02);
        enter_wait();
        for (int i = 0; i < 4; i++) begin
            chk("R8 sys off", 8'(sys_run_en), 8'h0);
            chk("R8 core off", 8'(core_run_en), 8'h0);
            chk("R8 bus off", 8'(bus_en), 8'h0);
            cyc();
        end
        leave_wait();
        chk("R8 sys back", 8'(sys_run_en), 8'h1);
        chk("R8 core back", 8'(core_run_en), 8'h1);
    endtask

    task automatic t_wait_core();
        int ones;
        write_ctrl(6'h04);
        enter_wait();
        ones = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R9 sys on", 8'(sys_run_en), 8'h1);
            chk("R9 core off", 8'(core_run_en), 8'h0);
            if (bus_en) ones++;
            cyc();
        end
        chk("R9 bus pulses", 8'(ones), 8'd2);
        leave_wait();
        chk("R9 core back", 8'(core_run_en), 8'h1);
    endtask

    task automatic t_warn();
        chk("R10 no warn locked", 8'(lock_warn), 8'h0);
        pll_lock = 1'b0;
        write_ctrl(6'h01);
        chk("R10 accepted", 8'(ctrl_q[0]), 8'h1);
        chk("R10 warn set", 8'(lock_warn), 8'h1);
        pll_lock = 1'b1;
        write_ctrl(6'h00);
        repeat (2) cyc();
        chk("R10 sticky", 8'(lock_warn), 8'h1);
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_write();
        t_source();
        t_wait_pll();
        t_wait_sys();
        t_wait_core();
        t_warn();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule